// File: doc/BRIEF.md
# Multi-Slot Conversion-Start Scheduler

This block sits in front of an analog-to-digital converter and decides which conversion runs next. It holds sixteen independent slot descriptors. Each descriptor names the event that starts it, the analog channel to convert and the length of the sample window. Any number of slots may point at the same trigger, channel or window length. One trigger can therefore launch a burst of conversions on different channels, oversample a single channel, or serve unrelated sources slot by slot.

Trigger events come from twelve external pulse lines, two feedback pulse lines or a per-slot software force. Each event latches a pending flag on its slot. An event that lands on a slot that is already pending sets a sticky overflow bit and is otherwise dropped. A round-robin arbiter picks one pending slot at a time. The block then runs that slot's sample window and raises a convert request tagged with the channel and the slot index. The slot index also selects the result register. The request is held until the converter returns a done pulse.

Top module: `socScheduler`

## Requirements
- R1: The slot control word is split as follows: window field in bits [5:0], channel in bits [9:6], bit 10 unused, trigger select in bits [15:11]. Writing 16'h4846 gives window 6, channel 1 and trigger 9.
- R2: `sampling` goes high one cycle after a slot is picked and stays high for window+1 cycles. A window field below 6 is treated as 6, so no window is shorter than 7 cycles.
- R3: With source code 0, a trigger select of 0 gives no hardware event. A value n from 1 to 12 takes its event from `extTrig[n-1]`. Values 13 to 31 give no event.
- R4: The 2-bit source code of a slot selects its hardware event source: 0 uses the trigger-select path, 1 uses `intFb[0]`, 2 uses `intFb[1]`, and 3 gives no hardware event.
- R5: A cycle with `forceWe` high raises an event on every slot i whose `forceMask[i]` is 1, whatever the slot's configuration.
- R6: An event sets the slot's bit in `pendingFlags`. The bit stays set until that slot is picked for conversion.
- R7: An event on a slot whose pending bit is already set, and that is not being picked in the same cycle, sets its `overflowFlags` bit. That bit stays set. The extra event yields no second conversion.
- R8: A cycle with `ovfClrWe` high clears the overflow bits selected by `ovfClrMask`. If an overflow is set in the same cycle, the set wins.
- R9: Among the pending slots, the next one picked is the first found when searching upward and wrapping, starting one past the last slot picked. After reset the search starts at slot 0.
- R10: Only one conversion is in flight. After the window, `convReq` stays high until `convDone`, with no new window in the meantime.
- R11: While `convReq` is high, `convSlot` and `convChan` hold the picked slot's index and channel field without change.
- R12: After reset, no slot is pending, no overflow bit is set, and `busy`, `sampling` and `convReq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Write `cfgData` into the control word of slot `cfgAddr` |
| srcWe | input | 1 | Write `srcData` into the source code of slot `cfgAddr` |
| cfgAddr | input | 4 | Slot addressed by configuration writes |
| cfgData | input | 16 | Slot control word |
| srcData | input | 2 | Slot source code |
| forceWe | input | 1 | Software force strobe |
| forceMask | input | 16 | Slots to force |
| ovfClrWe | input | 1 | Overflow clear strobe |
| ovfClrMask | input | 16 | Overflow bits to clear |
| extTrig | input | 12 | External trigger pulses, line n on bit n-1 |
| intFb | input | 2 | Feedback trigger pulses |
| convDone | input | 1 | Converter done pulse |
| convReq | output | 1 | Convert request, held until done |
| convChan | output | 4 | Channel of the current conversion |
| convSlot | output | 4 | Slot and result index of the current conversion |
| sampling | output | 1 | Sample window active |
| busy | output | 1 | A slot is sampling or converting |
| pendingFlags | output | 16 | Latched pending flags per slot |
| overflowFlags | output | 16 | Sticky overflow flags per slot |

## Verification
The bench sweeps every window field value and checks the measured window length. A missing clamp shows up as windows shorter than seven cycles, and an off-by-one shows up as every length being one cycle wrong. It tries every trigger select against every external line and every source code against every source. A decoder that reads the wrong bit slice, or that lets an out-of-range select wrap, therefore fires the wrong slot. Overflow is checked with a slot held pending behind a stalled conversion, including a clear in the same cycle as a set, where a design that gives the clear priority loses the bit. Arbitration order is checked after several different last-served slots and after reset, where a fixed-priority or misaligned pointer serves slots in the wrong order.

// File: rtl/socSchedPkg.sv
package socSchedPkg;
  localparam int CTRL_W        = 16;
  localparam int WIN_LSB       = 0;
  localparam int WIN_W         = 6;
  localparam int CH_LSB        = 6;
  localparam int CH_W          = 4;
  localparam int TRIG_LSB      = 11;
  localparam int TRIG_W        = 5;
  localparam int SRC_W         = 2;
  localparam int MIN_WIN_FIELD = 6;

  typedef enum logic [1:0] {
    SRC_TRIGSEL = 2'd0,
    SRC_FB1     = 2'd1,
    SRC_FB2     = 2'd2,
    SRC_NONE    = 2'd3
  } trigSrc_t;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_SAMPLE  = 2'd1,
    ST_CONVERT = 2'd2
  } schedState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic startConv;
  } schedStrobe_t;
endpackage

// File: rtl/socSchedDatapath.sv
module socSchedDatapath
  import socSchedPkg::*;
#(
  parameter int NUM_SLOTS = 16,
  parameter int NUM_EXT   = 12,
  parameter int IDX_W     = $clog2(NUM_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cfgWe,
  input  logic                 srcWe,
  input  logic [IDX_W-1:0]     cfgAddr,
  input  logic [CTRL_W-1:0]    cfgData,
  input  logic [SRC_W-1:0]     srcData,
  input  logic                 forceWe,
  input  logic [NUM_SLOTS-1:0] forceMask,
  input  logic                 ovfClrWe,
  input  logic [NUM_SLOTS-1:0] ovfClrMask,
  input  logic [NUM_EXT-1:0]   extTrig,
  input  logic [1:0]           intFb,
  input  schedStrobe_t         strobe,
  input  logic [IDX_W-1:0]     grantIdx,
  output logic [WIN_W-1:0]     grantWin,
  output logic [CH_W-1:0]      convChan,
  output logic [IDX_W-1:0]     convSlot,
  output logic [NUM_SLOTS-1:0] pendingFlags,
  output logic [NUM_SLOTS-1:0] overflowFlags
);

  logic [CTRL_W-1:0]    ctrlWord [NUM_SLOTS];
  logic [SRC_W-1:0]     srcSel   [NUM_SLOTS];
  logic [NUM_SLOTS-1:0] slotEvt;
  logic [NUM_SLOTS-1:0] startClr;
  logic [NUM_SLOTS-1:0] pendQ;
  logic [NUM_SLOTS-1:0] ovfQ;
  logic [NUM_SLOTS-1:0] clrMask;
  logic [WIN_W-1:0]     rawWin;
  logic [CH_W-1:0]      chanQ;
  logic [IDX_W-1:0]     slotQ;

  // Configuration storage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < NUM_SLOTS; s++) begin
        ctrlWord[s] <= '0;
        srcSel[s]   <= '0;
      end
    end else begin
      if (cfgWe) ctrlWord[cfgAddr] <= cfgData;
      if (srcWe) srcSel[cfgAddr]   <= srcData;
    end
  end

  // Per-slot event decode
  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    logic [TRIG_W-1:0] trigField;
    logic              lineHit;
    logic              hwEvt;

    assign trigField = ctrlWord[g][TRIG_LSB +: TRIG_W];

    always_comb begin
      lineHit = 1'b0;
      for (int l = 0; l < NUM_EXT; l++) begin
        if (trigField == TRIG_W'(l + 1)) lineHit = extTrig[l];
      end
    end

    always_comb begin
      case (trigSrc_t'(srcSel[g]))
        SRC_TRIGSEL: hwEvt = lineHit;
        SRC_FB1:     hwEvt = intFb[0];
        SRC_FB2:     hwEvt = intFb[1];
        default:     hwEvt = 1'b0;
      endcase
    end

    assign slotEvt[g]  = hwEvt | (forceWe & forceMask[g]);
    assign startClr[g] = strobe.startConv && (grantIdx == IDX_W'(g));
  end

  assign clrMask = ovfClrWe ? ovfClrMask : '0;

  // Pending and overflow flags; set beats clear on overflow
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendQ <= '0;
      ovfQ  <= '0;
    end else begin
      pendQ <= (pendQ & ~startClr) | slotEvt;
      ovfQ  <= (ovfQ & ~clrMask) | (slotEvt & pendQ & ~startClr);
    end
  end

  // Window of the candidate slot, clamped to the shortest legal value
  assign rawWin   = ctrlWord[grantIdx][WIN_LSB +: WIN_W];
  assign grantWin = (rawWin < WIN_W'(MIN_WIN_FIELD)) ? WIN_W'(MIN_WIN_FIELD) : rawWin;

  // Conversion tag captured at start
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chanQ <= '0;
      slotQ <= '0;
    end else if (strobe.startConv) begin
      chanQ <= ctrlWord[grantIdx][CH_LSB +: CH_W];
      slotQ <= grantIdx;
    end
  end

  assign convChan      = chanQ;
  assign convSlot      = slotQ;
  assign pendingFlags  = pendQ;
  assign overflowFlags = ovfQ;

endmodule

// File: rtl/socSchedControl.sv
module socSchedControl
  import socSchedPkg::*;
#(
  parameter int NUM_SLOTS = 16,
  parameter int IDX_W     = $clog2(NUM_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_SLOTS-1:0] pendingFlags,
  input  logic [WIN_W-1:0]     grantWin,
  input  logic                 convDone,
  output schedStrobe_t         strobe,
  output logic [IDX_W-1:0]     grantIdx,
  output logic                 sampling,
  output logic                 convReq,
  output logic                 busy
);

  schedState_t      state;
  logic [IDX_W-1:0] rrBase;
  logic [WIN_W-1:0] winCnt;
  logic             anyPend;
  logic             found;
  logic [IDX_W:0]   sum;
  logic [IDX_W-1:0] nextBase;

  assign anyPend = |pendingFlags;

  // Round-robin search from rrBase, wrapping at NUM_SLOTS
  always_comb begin
    grantIdx = rrBase;
    found    = 1'b0;
    sum      = '0;
    for (int k = 0; k < NUM_SLOTS; k++) begin
      sum = {1'b0, rrBase} + (IDX_W+1)'(k);
      if (sum >= (IDX_W+1)'(NUM_SLOTS)) sum = sum - (IDX_W+1)'(NUM_SLOTS);
      if (!found && pendingFlags[sum[IDX_W-1:0]]) begin
        found    = 1'b1;
        grantIdx = sum[IDX_W-1:0];
      end
    end
  end

  assign nextBase = (grantIdx == IDX_W'(NUM_SLOTS - 1)) ? '0 : grantIdx + 1'b1;

  assign strobe.startConv = (state == ST_IDLE) && anyPend;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      rrBase <= '0;
      winCnt <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (anyPend) begin
            state  <= ST_SAMPLE;
            winCnt <= grantWin;
            rrBase <= nextBase;
          end
        end
        ST_SAMPLE: begin
          if (winCnt == '0) state <= ST_CONVERT;
          else              winCnt <= winCnt - 1'b1;
        end
        ST_CONVERT: begin
          if (convDone) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign sampling = (state == ST_SAMPLE);
  assign convReq  = (state == ST_CONVERT);
  assign busy     = (state != ST_IDLE);

endmodule

// File: rtl/socScheduler.sv
module socScheduler
  import socSchedPkg::*;
#(
  parameter int NUM_SLOTS = 16,
  parameter int NUM_EXT   = 12,
  parameter int IDX_W     = $clog2(NUM_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cfgWe,
  input  logic                 srcWe,
  input  logic [IDX_W-1:0]     cfgAddr,
  input  logic [CTRL_W-1:0]    cfgData,
  input  logic [SRC_W-1:0]     srcData,
  input  logic                 forceWe,
  input  logic [NUM_SLOTS-1:0] forceMask,
  input  logic                 ovfClrWe,
  input  logic [NUM_SLOTS-1:0] ovfClrMask,
  input  logic [NUM_EXT-1:0]   extTrig,
  input  logic [1:0]           intFb,
  input  logic                 convDone,
  output logic                 convReq,
  output logic [CH_W-1:0]      convChan,
  output logic [IDX_W-1:0]     convSlot,
  output logic                 sampling,
  output logic                 busy,
  output logic [NUM_SLOTS-1:0] pendingFlags,
  output logic [NUM_SLOTS-1:0] overflowFlags
);

  schedStrobe_t     strobe;
  logic [IDX_W-1:0] grantIdx;
  logic [WIN_W-1:0] grantWin;

  socSchedDatapath #(
    .NUM_SLOTS(NUM_SLOTS), .NUM_EXT(NUM_EXT), .IDX_W(IDX_W)
  ) u_datapath (
    .clk(clk), .rstN(rstN),
    .cfgWe(cfgWe), .srcWe(srcWe), .cfgAddr(cfgAddr),
    .cfgData(cfgData), .srcData(srcData),
    .forceWe(forceWe), .forceMask(forceMask),
    .ovfClrWe(ovfClrWe), .ovfClrMask(ovfClrMask),
    .extTrig(extTrig), .intFb(intFb),
    .strobe(strobe), .grantIdx(grantIdx), .grantWin(grantWin),
    .convChan(convChan), .convSlot(convSlot),
    .pendingFlags(pendingFlags), .overflowFlags(overflowFlags)
  );

  socSchedControl #(
    .NUM_SLOTS(NUM_SLOTS), .IDX_W(IDX_W)
  ) u_control (
    .clk(clk), .rstN(rstN),
    .pendingFlags(pendingFlags), .grantWin(grantWin), .convDone(convDone),
    .strobe(strobe), .grantIdx(grantIdx),
    .sampling(sampling), .convReq(convReq), .busy(busy)
  );

endmodule

// File: rtl/socSchedChecker.sv
module socSchedChecker
  import socSchedPkg::*;
#(
  parameter int NUM_SLOTS = 16,
  parameter int IDX_W     = $clog2(NUM_SLOTS)
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 sampling,
  input logic                 convReq,
  input logic                 convDone,
  input logic [IDX_W-1:0]     convSlot,
  input logic [CH_W-1:0]      convChan,
  input logic [NUM_SLOTS-1:0] pendingFlags,
  input logic [NUM_SLOTS-1:0] overflowFlags
);

  logic [7:0] sampLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          sampLen <= '0;
    else if (!sampling)                 sampLen <= '0;
    else if (sampLen != 8'hFF)          sampLen <= sampLen + 1'b1;
  end

  // R2
  min_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sampling) |-> (sampLen >= 8'd7));

  // R10
  conv_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (convReq && !convDone) |=> convReq);

  // R10
  one_phase_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(sampling && convReq));

  // R11
  conv_tag_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (convReq && !convDone) |=> ($stable(convSlot) && $stable(convChan)));

  // R7
  ovf_needs_pend_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((overflowFlags & ~$past(overflowFlags) & ~$past(pendingFlags)) == '0));

endmodule

bind socScheduler socSchedChecker #(.NUM_SLOTS(NUM_SLOTS), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rstN(rstN), .sampling(sampling), .convReq(convReq),
  .convDone(convDone), .convSlot(convSlot), .convChan(convChan),
  .pendingFlags(pendingFlags), .overflowFlags(overflowFlags)
);

// File: tb/socScheduler_tb.sv
`timescale 1ns/100ps
module socScheduler_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0, srcWe = 1'b0;
  logic [3:0]  cfgAddr = '0;
  logic [15:0] cfgData = '0;
  logic [1:0]  srcData = '0;
  logic        forceWe = 1'b0;
  logic [15:0] forceMask = '0;
  logic        ovfClrWe = 1'b0;
  logic [15:0] ovfClrMask = '0;
  logic [11:0] extTrig = '0;
  logic [1:0]  intFb = '0;
  logic        convDone = 1'b0;
  logic        convReq, sampling, busy;
  logic [3:0]  convChan, convSlot;
  logic [15:0] pendingFlags, overflowFlags;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  socScheduler u_dut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .srcWe(srcWe), .cfgAddr(cfgAddr),
    .cfgData(cfgData), .srcData(srcData), .forceWe(forceWe), .forceMask(forceMask),
    .ovfClrWe(ovfClrWe), .ovfClrMask(ovfClrMask), .extTrig(extTrig), .intFb(intFb),
    .convDone(convDone), .convReq(convReq), .convChan(convChan), .convSlot(convSlot),
    .sampling(sampling), .busy(busy), .pendingFlags(pendingFlags),
    .overflowFlags(overflowFlags)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chkEq(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic writeCfg(input int idx, input logic [15:0] word);
    cfgAddr = 4'(idx); cfgData = word; cfgWe = 1'b1;
    tick();
    cfgWe = 1'b0;
  endtask

  task automatic writeSrc(input int idx, input logic [1:0] code);
    cfgAddr = 4'(idx); srcData = code; srcWe = 1'b1;
    tick();
    srcWe = 1'b0;
  endtask

  task automatic forcePulse(input logic [15:0] mask);
    forceMask = mask; forceWe = 1'b1;
    tick();
    forceWe = 1'b0;
  endtask

  task automatic extPulse(input int line);
    extTrig[line-1] = 1'b1;
    tick();
    extTrig = '0;
  endtask

  task automatic waitConv();
    for (int g = 0; g < 500 && !convReq; g++) tick();
  endtask

  // Waits for the request, counts window cycles, then answers with done
  task automatic serveOne(output int slot, output int chan, output int slen);
    int guard;
    slen = 0;
    guard = 0;
    while (!convReq && guard < 500) begin
      if (sampling) slen++;
      tick();
      guard++;
    end
    if (!convReq) chkEq("R10 request never raised", 0, 1);
    slot = int'(convSlot);
    chan = int'(convChan);
    convDone = 1'b1;
    tick();
    convDone = 1'b0;
  endtask

  task automatic rrCase(input int b, input logic [15:0] mask);
    int s, c, l;
    forcePulse(16'(1 << b));
    waitConv();
    forcePulse(mask);
    serveOne(s, c, l);
    chkEq("R9 blocking slot", s, b);
    for (int k = 1; k <= 16; k++) begin
      int idx;
      idx = (b + k) % 16;
      if (mask[idx]) begin
        serveOne(s, c, l);
        chkEq("R9 round-robin order", s, idx);
        chkEq("R11 channel tag", c, idx);
      end
    end
    chkEq("R9 all served", int'(pendingFlags), 0);
  endtask

  initial begin
    int s, c, l;
    tick(); tick();
    // R12 reset state
    chkEq("R12 pending at reset", int'(pendingFlags), 0);
    chkEq("R12 overflow at reset", int'(overflowFlags), 0);
    chkEq("R12 idle at reset", int'({busy, sampling, convReq}), 0);
    rstN = 1'b1;
    tick();

    // R2 / R11: every window field value on slot 0
    for (int w = 0; w < 64; w++) begin
      writeCfg(0, {5'd0, 1'b0, 4'(w % 16), 6'(w)});
      forcePulse(16'h0001);
      serveOne(s, c, l);
      chkEq("R2 window length", l, ((w < 6) ? 6 : w) + 1);
      chkEq("R11 slot tag", s, 0);
      chkEq("R11 channel tag", c, w % 16);
    end
    writeCfg(0, 16'h0000);

    // R1 field decode
    writeCfg(5, 16'h4846);
    extPulse(9);
    chkEq("R1 trigger 9 pends slot 5", int'(pendingFlags), 16'h0020);
    serveOne(s, c, l);
    chkEq("R1 slot", s, 5);
    chkEq("R1 channel 1", c, 1);
    chkEq("R1 window 6 -> 7 cycles", l, 7);
    writeCfg(5, 16'h0000);

    // R3 trigger select against every external line
    for (int t = 0; t < 32; t++) begin
      writeCfg(3, {5'(t), 1'b0, 4'd3, 6'd6});
      for (int line = 1; line <= 12; line++) begin
        extPulse(line);
        chkEq("R3 select vs line", int'(pendingFlags), (t == line) ? 16'h0008 : 0);
        if (t == line) begin
          serveOne(s, c, l);
          chkEq("R3 served slot", s, 3);
        end
      end
    end
    writeCfg(3, 16'h0000);

    // R4 source code sweep
    writeCfg(7, {5'd4, 1'b0, 4'd7, 6'd6});
    for (int code = 0; code < 4; code++) begin
      writeSrc(7, 2'(code));
      for (int stim = 0; stim < 3; stim++) begin
        bit hit;
        hit = (code == 0 && stim == 0) || (code == 1 && stim == 1) || (code == 2 && stim == 2);
        if (stim == 0) extTrig[3] = 1'b1;
        else           intFb[stim-1] = 1'b1;
        tick();
        extTrig = '0; intFb = '0;
        chkEq("R4 source select", int'(pendingFlags), hit ? 16'h0080 : 0);
        if (hit) serveOne(s, c, l);
      end
    end
    writeSrc(7, 2'd0);
    writeCfg(7, 16'h0000);

    // R6 R7 R8 R10 with a stalled conversion
    writeCfg(0, {5'd0, 1'b0, 4'd2, 6'd6});
    writeCfg(9, {5'd0, 1'b0, 4'd9, 6'd6});
    forcePulse(16'h0001);
    waitConv();
    forcePulse(16'h0200);
    chkEq("R6 pending latched", int'(pendingFlags), 16'h0200);
    chkEq("R7 no overflow on first event", int'(overflowFlags), 0);
    repeat (20) tick();
    chkEq("R10 request held without done", int'(convReq), 1);
    chkEq("R10 no window while converting", int'(sampling), 0);
    chkEq("R6 pending still latched", int'(pendingFlags), 16'h0200);
    forcePulse(16'h0200);
    chkEq("R7 overflow on second event", int'(overflowFlags), 16'h0200);
    repeat (3) tick();
    chkEq("R7 overflow sticky", int'(overflowFlags), 16'h0200);
    forceMask = 16'h0200; forceWe = 1'b1;
    ovfClrMask = 16'h0200; ovfClrWe = 1'b1;
    tick();
    forceWe = 1'b0; ovfClrWe = 1'b0;
    chkEq("R8 set wins over clear", int'(overflowFlags), 16'h0200);
    ovfClrMask = 16'h0200; ovfClrWe = 1'b1;
    tick();
    ovfClrWe = 1'b0;
    chkEq("R8 clear", int'(overflowFlags), 0);
    serveOne(s, c, l);
    chkEq("R10 stalled slot", s, 0);
    serveOne(s, c, l);
    chkEq("R6 pending slot served", s, 9);
    repeat (5) tick();
    chkEq("R7 extra event not queued", int'({busy, pendingFlags}), 0);

    // Channel equals slot index for the remaining tests
    for (int i = 0; i < 16; i++) writeCfg(i, {5'd0, 1'b0, 4'(i), 6'd6});

    // R5 force each slot alone
    for (int i = 0; i < 16; i++) begin
      forcePulse(16'(1 << i));
      chkEq("R5 force sets pending", int'(pendingFlags), 1 << i);
      serveOne(s, c, l);
      chkEq("R5 forced slot served", s, i);
    end

    // R9 arbitration order
    rrCase(0, 16'hFFFF);
    rrCase(5, 16'h0421);
    rrCase(15, 16'h8001);
    rrCase(10, 16'h0C03);

    // R9 / R12 after a second reset
    rstN = 1'b0;
    tick();
    chkEq("R12 pending cleared by reset", int'(pendingFlags), 0);
    chkEq("R12 idle after reset", int'({busy, convReq}), 0);
    rstN = 1'b1;
    tick();
    forcePulse(16'h8001);
    serveOne(s, c, l);
    chkEq("R9 slot 0 first after reset", s, 0);
    serveOne(s, c, l);
    chkEq("R9 then slot 15", s, 15);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule